// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a small read-allocating data cache. A direct-mapped line array is backed by a fully associative buffer of four recently displaced lines. A CPU read that hits the line array completes in the same cycle it is presented.

A read that misses the array but matches a buffered line swaps the two lines: the buffered line moves into the array and the line it replaces takes the freed buffer slot. The read then completes one cycle later, with no memory traffic. A read that misses both structures fetches the whole line over a request/acknowledge memory port. The line that is pushed out of the array is kept in the buffer. When the buffer is full, its least recently used entry is overwritten.

Writes always go through to memory one word at a time and never allocate. A write that finds its line in either structure also updates that copy.

The CPU holds `cpu_req` and its operands steady until `cpu_ready` is seen high at a clock edge. The memory side holds `mem_req` until it sees `mem_ack`, which lasts one cycle.

Top module: `dmvc_cache`

## Requirements
- R1: After reset every line in the array and in the buffer is invalid. `cpu_ready` and `mem_req` are low, and the first read of any address causes a memory line read.
- R2: A read whose line is in the array raises `cpu_ready` in the same cycle as `cpu_req`. `cpu_rdata` carries the addressed word and `mem_req` stays low.
- R3: A read that misses both structures issues one memory read with `mem_we` low. `mem_addr` is the line address with its two low bits zero and stays stable until `mem_ack`. Word k of the line is taken from `mem_rdata[32k+31:32k]`, and the requested word is returned once the line is installed.
- R4: A valid line displaced from the array by a fill is kept in the buffer, so a later read of it makes no memory access.
- R5: A read that hits only the buffer is served without a memory access, one cycle later than an array hit (`cpu_ready` in the second cycle of the request). The buffered line and the array line at that index exchange places.
- R6: The buffer holds four lines. When it is full and a line must be inserted, the least recently used entry is overwritten. Insertion and a buffer read hit both make an entry most recently used; a buffer write hit does not change the order.
- R7: Every write issues one memory write with `mem_we` high, `mem_addr` equal to `cpu_addr` and `mem_wdata` equal to `cpu_wdata`. `cpu_ready` rises in the cycle of `mem_ack`.
- R8: A write whose line is in the array also updates the array copy, so a following read returns the new word without memory access.
- R9: A write whose line is in the buffer also updates the buffered copy.
- R10: A write that misses both structures allocates nothing; a following read of that address fetches from memory.
- R11: A line is never present in the array and the buffer at once, and at most one buffer entry matches any line address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held until accepted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address: tag, index, word offset |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_ready` on reads |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = word write, 0 = line read |
| mem_addr | output | ADDR_W | Line-aligned address for reads, word address for writes |
| mem_wdata | output | DATA_W | Word written to memory |
| mem_rdata | input | DATA_W*4 | Whole line returned with `mem_ack` |
| mem_ack | input | 1 | Memory completes the request, one cycle |

## Verification
The hardest cycle is the fill edge when the buffer is already full. In that single edge the fetched line is written into the array, the displaced array line is inserted into the buffer, and the least recently used buffer entry is overwritten, all while the recency order is updated.

The bench fills the buffer with four lines that share one index. It then re-hits an older entry to reorder recency and forces two more fills. The outcome is judged afterwards from port behaviour alone: which addresses are then served without memory traffic, with the one-cycle swap latency, and which ones cause a fresh line read.

// File: rtl/dmvc_pkg.sv
package dmvc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WRITE = 2'd2
  } dmvc_state_e;
endpackage

// File: rtl/dmvc_main.sv
module dmvc_main #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_line  = line_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      tag_q[wr_idx]   <= wr_tag;
      line_q[wr_idx]  <= wr_line;
    end
  end
endmodule

// File: rtl/dmvc_victim.sv
module dmvc_victim #(
  parameter int LADDR_W = 8,
  parameter int LINE_W  = 128,
  parameter int N       = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LADDR_W-1:0] lk_laddr,
  output logic               hit,
  output logic [$clog2(N)-1:0] hit_slot,
  output logic [LINE_W-1:0]  hit_line,
  output logic [$clog2(N)-1:0] repl_slot,
  input  logic               wr_en,
  input  logic [$clog2(N)-1:0] wr_slot,
  input  logic               wr_valid,
  input  logic [LADDR_W-1:0] wr_laddr,
  input  logic [LINE_W-1:0]  wr_line,
  input  logic               wr_touch
);
  localparam int SLOT_W = $clog2(N);

  logic [N-1:0]       v_q;
  logic [LADDR_W-1:0] la_q  [N];
  logic [LINE_W-1:0]  ln_q  [N];
  logic [SLOT_W-1:0]  age_q [N];
  logic [N-1:0]       hit_vec;
  logic [N-1:0]       age_seen;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = v_q[g] && (la_q[g] == lk_laddr);
  end

  always_comb begin
    hit_slot = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i]) hit_slot = i[SLOT_W-1:0];
  end
  assign hit      = |hit_vec;
  assign hit_line = ln_q[hit_slot];

  // replacement choice: lowest free slot, else the oldest entry
  always_comb begin
    logic found;
    found     = 1'b0;
    repl_slot = '0;
    for (int i = 0; i < N; i++)
      if (!found && !v_q[i]) begin
        repl_slot = i[SLOT_W-1:0];
        found     = 1'b1;
      end
    if (!found)
      for (int i = 0; i < N; i++)
        if (age_q[i] == SLOT_W'(N-1)) repl_slot = i[SLOT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int i = 0; i < N; i++) age_q[i] <= SLOT_W'(i);
    end else if (wr_en) begin
      v_q[wr_slot]  <= wr_valid;
      la_q[wr_slot] <= wr_laddr;
      ln_q[wr_slot] <= wr_line;
      if (wr_touch)
        for (int j = 0; j < N; j++) begin
          if (j == int'(wr_slot))            age_q[j] <= '0;
          else if (age_q[j] < age_q[wr_slot]) age_q[j] <= age_q[j] + 1'b1;
        end
    end
  end

  always_comb begin
    age_seen = '0;
    for (int i = 0; i < N; i++) age_seen[age_q[i]] = 1'b1;
  end

  // R11
  vb_single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R6
  vb_age_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    age_seen == {N{1'b1}});
endmodule

// File: rtl/dmvc_cache.sv
module dmvc_cache #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 3,
  parameter int VB_N   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_req,
  input  logic                          cpu_we,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [DATA_W-1:0]             cpu_wdata,
  output logic [DATA_W-1:0]             cpu_rdata,
  output logic                          cpu_ready,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [DATA_W-1:0]             mem_wdata,
  input  logic [DATA_W*(1<<OFF_W)-1:0]  mem_rdata,
  input  logic                          mem_ack
);
  import dmvc_pkg::*;

  localparam int WPL     = 1 << OFF_W;
  localparam int LINE_W  = DATA_W * WPL;
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
  localparam int LADDR_W = ADDR_W - OFF_W;
  localparam int SLOT_W  = $clog2(VB_N);

  function automatic logic [DATA_W-1:0] word_of(input logic [LINE_W-1:0] ln,
                                                input logic [OFF_W-1:0] o);
    return ln[int'(o)*DATA_W +: DATA_W];
  endfunction

  function automatic logic [LINE_W-1:0] word_put(input logic [LINE_W-1:0] ln,
                                                 input logic [OFF_W-1:0] o,
                                                 input logic [DATA_W-1:0] d);
    logic [LINE_W-1:0] r;
    r = ln;
    r[int'(o)*DATA_W +: DATA_W] = d;
    return r;
  endfunction

  dmvc_state_e state_q, state_d;

  logic [OFF_W-1:0]   a_off;
  logic [IDX_W-1:0]   a_idx;
  logic [TAG_W-1:0]   a_tag;
  logic [LADDR_W-1:0] a_laddr;
  assign a_off   = cpu_addr[OFF_W-1:0];
  assign a_idx   = cpu_addr[OFF_W +: IDX_W];
  assign a_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
  assign a_laddr = cpu_addr[ADDR_W-1:OFF_W];

  logic              m_valid;
  logic [TAG_W-1:0]  m_tag;
  logic [LINE_W-1:0] m_line;
  logic              m_wr_en;
  logic [TAG_W-1:0]  m_wr_tag;
  logic [LINE_W-1:0] m_wr_line;

  logic              v_hit;
  logic [SLOT_W-1:0] v_hit_slot, v_repl_slot, v_wr_slot;
  logic [LINE_W-1:0] v_hit_line, v_wr_line;
  logic              v_wr_en, v_wr_valid, v_wr_touch;
  logic [LADDR_W-1:0] v_wr_laddr;

  dmvc_main #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) main_i (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(a_idx), .rd_valid(m_valid), .rd_tag(m_tag), .rd_line(m_line),
    .wr_en(m_wr_en), .wr_idx(a_idx), .wr_tag(m_wr_tag), .wr_line(m_wr_line)
  );

  dmvc_victim #(.LADDR_W(LADDR_W), .LINE_W(LINE_W), .N(VB_N)) vb_i (
    .clk(clk), .rst_n(rst_n),
    .lk_laddr(a_laddr), .hit(v_hit), .hit_slot(v_hit_slot), .hit_line(v_hit_line),
    .repl_slot(v_repl_slot),
    .wr_en(v_wr_en), .wr_slot(v_wr_slot), .wr_valid(v_wr_valid),
    .wr_laddr(v_wr_laddr), .wr_line(v_wr_line), .wr_touch(v_wr_touch)
  );

  // named events for assertions
  logic main_hit, ev_rd_hit, ev_swap, ev_miss, ev_fill, ev_wr_done;
  assign main_hit   = m_valid && (m_tag == a_tag);
  assign ev_rd_hit  = (state_q == ST_IDLE) && cpu_req && !cpu_we && main_hit;
  assign ev_swap    = (state_q == ST_IDLE) && cpu_req && !cpu_we && !main_hit && v_hit;
  assign ev_miss    = (state_q == ST_IDLE) && cpu_req && !cpu_we && !main_hit && !v_hit;
  assign ev_fill    = (state_q == ST_FETCH) && mem_ack;
  assign ev_wr_done = (state_q == ST_WRITE) && mem_ack;

  always_comb begin
    state_d    = state_q;
    m_wr_en    = 1'b0;
    m_wr_tag   = a_tag;
    m_wr_line  = m_line;
    v_wr_en    = 1'b0;
    v_wr_slot  = v_hit_slot;
    v_wr_valid = 1'b1;
    v_wr_laddr = {m_tag, a_idx};
    v_wr_line  = m_line;
    v_wr_touch = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req && cpu_we) state_d = ST_WRITE;
        else if (ev_miss)      state_d = ST_FETCH;
        if (ev_swap) begin
          m_wr_en    = 1'b1;
          m_wr_line  = v_hit_line;
          v_wr_en    = 1'b1;
          v_wr_valid = m_valid;
          v_wr_touch = 1'b1;
        end
      end
      ST_FETCH: if (mem_ack) begin
        state_d    = ST_IDLE;
        m_wr_en    = 1'b1;
        m_wr_line  = mem_rdata;
        v_wr_en    = m_valid;
        v_wr_slot  = v_repl_slot;
        v_wr_touch = 1'b1;
      end
      ST_WRITE: if (mem_ack) begin
        state_d = ST_IDLE;
        if (main_hit) begin
          m_wr_en   = 1'b1;
          m_wr_line = word_put(m_line, a_off, cpu_wdata);
        end else if (v_hit) begin
          v_wr_en    = 1'b1;
          v_wr_laddr = a_laddr;
          v_wr_line  = word_put(v_hit_line, a_off, cpu_wdata);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign cpu_ready = ev_rd_hit || ev_wr_done;
  assign cpu_rdata = word_of(m_line, a_off);
  assign mem_req   = (state_q != ST_IDLE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = (state_q == ST_WRITE) ? cpu_addr : {a_laddr, {OFF_W{1'b0}}};
  assign mem_wdata = cpu_wdata;

  // R11
  excl_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && cpu_req) |-> !(main_hit && v_hit));
  // R3
  memreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R2
  hit_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !cpu_we) |-> !mem_req);
  // R5
  swap_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_swap |=> (!mem_req && m_valid));
  // R7
  wr_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |-> (mem_req && mem_we && mem_ack));
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!mem_req && !cpu_ready));
endmodule

// File: tb/dmvc_cache_tb_top.sv
module dmvc_cache_tb_top;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int LW = DW * 4;
  localparam logic [1:0] K_HIT = 2'd0, K_VHIT = 2'd1, K_MISS = 2'd2, K_WR = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic cpu_ready, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [LW-1:0] mem_rdata = '0;
  logic mem_ack = 1'b0;

  always #10 clk = ~clk;

  dmvc_cache dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  int total = 0, fails = 0;
  bit done = 0;
  int n_rd = 0, n_wr = 0;
  logic [AW-1:0] last_wa;
  logic [DW-1:0] last_wd;
  logic [DW-1:0] mem_m [1<<AW];
  logic [DW-1:0] gold  [1<<AW];

  function automatic logic [DW-1:0] init_word(input int a);
    return 32'hA500_0000 ^ (a * 32'h9E37);
  endfunction

  function automatic logic [44:0] mk(input bit we, input logic [1:0] k,
                                     input int tg, input int ix, input int of,
                                     input logic [31:0] wd);
    logic [AW-1:0] a;
    a = AW'(tg * 32 + ix * 4 + of);
    return {we, k, a, wd};
  endfunction

  localparam logic [44:0] VEC [20] = '{
    mk(0, K_MISS, 1, 3, 0, 0),             // 0  R1 R3 cold miss
    mk(0, K_HIT,  1, 3, 2, 0),             // 1  R2 array hit
    mk(0, K_MISS, 2, 3, 1, 0),             // 2  R4 tag1 pushed to buffer
    mk(0, K_VHIT, 1, 3, 3, 0),             // 3  R4 R5 buffer hit, swap
    mk(0, K_VHIT, 2, 3, 0, 0),             // 4  R5 swap back
    mk(0, K_HIT,  2, 3, 0, 0),             // 5  R2
    mk(1, K_WR,   2, 3, 0, 32'h1111_2222), // 6  R7 R8 write hit array
    mk(0, K_HIT,  2, 3, 0, 0),             // 7  R8 new word, no memory
    mk(1, K_WR,   1, 3, 1, 32'h3333_4444), // 8  R9 write hit buffer
    mk(0, K_VHIT, 1, 3, 1, 0),             // 9  R9 R11 updated buffered copy
    mk(1, K_WR,   5, 6, 0, 32'h5555_6666), // 10 R10 write miss
    mk(0, K_MISS, 5, 6, 0, 0),             // 11 R10 not allocated
    mk(0, K_MISS, 3, 3, 0, 0),             // 12 R6 buffer fills
    mk(0, K_MISS, 4, 3, 0, 0),             // 13 R6
    mk(0, K_MISS, 6, 3, 0, 0),             // 14 R6 buffer full
    mk(0, K_VHIT, 1, 3, 0, 0),             // 15 R6 reorder recency
    mk(0, K_MISS, 7, 3, 0, 0),             // 16 R6 drops oldest (tag2)
    mk(0, K_MISS, 2, 3, 0, 0),             // 17 R6 tag2 gone
    mk(0, K_VHIT, 4, 3, 1, 0),             // 18 R6 tag4 kept
    mk(0, K_MISS, 3, 3, 0, 0)              // 19 R6 tag3 gone
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder: ack after two request cycles
  initial begin
    int lat;
    lat = 0;
    for (int a = 0; a < (1<<AW); a++) mem_m[a] = init_word(a);
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req) begin
        lat++;
        if (lat == 2) begin
          lat = 0;
          mem_ack = 1'b1;
          if (mem_we) begin
            mem_m[mem_addr] = mem_wdata;
            n_wr++;
            last_wa = mem_addr;
            last_wd = mem_wdata;
          end else begin
            chk(mem_addr[1:0] == 2'b00, "R3", "line read address aligned",
                32'(mem_addr), 32'(mem_addr & ~10'd3));
            for (int k = 0; k < 4; k++)
              mem_rdata[k*DW +: DW] = mem_m[{mem_addr[AW-1:2], 2'(k)}];
            n_rd++;
          end
        end
      end else lat = 0;
    end
  end

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int cyc);
    @(negedge clk);
    n_rd = 0; n_wr = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    cyc = 1;
    while (!cpu_ready && cyc < 60) begin
      @(negedge clk); #1;
      cyc++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  initial begin
    logic [DW-1:0] rd;
    int cyc;
    for (int a = 0; a < (1<<AW); a++) gold[a] = init_word(a);
    repeat (3) @(negedge clk);
    chk(cpu_ready == 1'b0, "R1", "ready low in reset", 32'(cpu_ready), 0);
    chk(mem_req == 1'b0, "R1", "mem_req low in reset", 32'(mem_req), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 20; i++) begin
      logic we; logic [1:0] k; logic [AW-1:0] a; logic [DW-1:0] wd;
      {we, k, a, wd} = VEC[i];
      access(we, a, wd, rd, cyc);
      case (k)
        K_HIT: begin
          chk(cyc == 1, "R2", $sformatf("vec %0d hit latency", i), 32'(cyc), 1);
          chk(n_rd == 0, "R2", $sformatf("vec %0d no memory", i), 32'(n_rd), 0);
        end
        K_VHIT: begin
          chk(cyc == 2, "R5", $sformatf("vec %0d buffer hit latency", i), 32'(cyc), 2);
          chk(n_rd == 0, "R5", $sformatf("vec %0d no memory", i), 32'(n_rd), 0);
        end
        K_MISS: chk(n_rd == 1, "R3", $sformatf("vec %0d one line read", i), 32'(n_rd), 1);
        default: begin
          gold[a] = wd;
          chk(n_wr == 1 && n_rd == 0, "R7", $sformatf("vec %0d one write", i),
              32'(n_wr), 1);
          chk(last_wa == a && last_wd == wd, "R7", $sformatf("vec %0d write word", i),
              last_wd, wd);
        end
      endcase
      if (!we)
        chk(rd == gold[a], "R3", $sformatf("vec %0d read data", i), rd, gold[a]);
    end

    // reset empties both structures
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    access(0, mk(0, 0, 4, 3, 1, 0) >> 32, 0, rd, cyc);
    chk(n_rd == 1, "R1", "array line invalid after reset", 32'(n_rd), 1);
    access(0, mk(0, 0, 6, 3, 0, 0) >> 32, 0, rd, cyc);
    chk(n_rd == 1, "R1", "buffer line invalid after reset", 32'(n_rd), 1);
    chk(rd == gold[(6*32+12)], "R3", "read data after reset", rd, gold[(6*32+12)]);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule